// File: doc/BRIEF.md
# Occupancy-Driven Light Controller with Vacancy Timer

This block turns a 3-bit head count of a room into lamp drive and a visible hold-off timer. While anybody is present, the number of lit lamps equals the head count, filled from lamp 0 upward. When the room empties, only lamp 0 stays on and a 60-second countdown starts. The lamp goes dark when the countdown reaches zero. A new arrival at any point reloads the full minute.

The remaining seconds are shown as two decimal digits on a four-digit, common-anode seven-segment display. The block scans the display itself, one digit at a time, and leaves the upper two digits dark. All logic runs on the system clock. A one-second enable pulse is made inside the block by counting clock cycles. The count input is a plain level: it carries no handshake, it is not debounced, and it is sampled on every clock edge.

Top module: `occupancy_lamp_ctrl`

## Requirements
- R1: On the clock edge after the count input is sampled nonzero, exactly the lowest `count` lamps are lit (lamp bit 0 upward), e.g. count 3 gives lamps 7'b0000111.
- R2: On the first clock edge at which the count is sampled as zero after an occupied period, the lamps become 7'b0000001 and the countdown shows 60.
- R3: While vacant, the countdown drops by one second every TICK_CYCLES clock edges, counted from the last occupied edge. It is held as two BCD digits, and a ones digit of 0 borrows to 9 from the tens digit (50 is followed by 49).
- R4: The countdown stops at 00 and never wraps. Lamp 0 turns off on the same edge at which the countdown reaches 00, and lamps stay off while vacant.
- R5: Any edge with a nonzero count reloads the countdown to 60 and restarts the one-second timebase, so after the room empties again the first decrement comes a full TICK_CYCLES edges later.
- R6: Segment and anode lines are active low. Segment bit 0 is segment a, up to bit 6 for segment g. Digits use the standard patterns (active-high a..g: 0=3F,1=06,2=5B,3=4F,4=66,5=6D,6=7D,7=07,8=7F,9=6F). Anode bit 0 low shows the ones digit and anode bit 1 low shows the tens digit.
- R7: Exactly one anode is low at any time. The active digit advances 0,1,2,3,0 every SCAN_DWELL clocks. While digit 2 or 3 is selected, all segments are off (7'h7F).
- R8: Synchronous reset turns all lamps off, sets the countdown to 00 and selects digit 0 (anodes 4'b1110).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| count_i | input | COUNT_W (3) | Number of occupants, treated as a level |
| lamps_o | output | LAMPS (7) | Lamp drive, active high, thermometer coded |
| seg_n_o | output | 7 | Segments a..g, active low |
| an_n_o | output | 4 | Digit anodes, active low |

## Verification
The bench targets the timing edges of the vacancy hold-off. It checks the last cycle before the first decrement and the cycle of that decrement. A design that let the second counter run free while occupied would decrement too early. It steps the countdown across a tens borrow, where a plain binary decrement would show a digit above 9. It watches the edge where the countdown reaches 00, because lamp 0 must go dark on that same edge and the value must not wrap to 99. It also brings a person back in the middle of a countdown, where a design that did not reload would resume from the old value.

// File: rtl/occ_pkg.sv
package occ_pkg;

  localparam int unsigned DIGITS = 4;
  localparam int unsigned SEG_W  = 7;

  // Active-high segment pattern, bit 0 = a ... bit 6 = g; non-decimal codes are blank.
  function automatic logic [SEG_W-1:0] seg_of_bcd(input logic [3:0] d);
    logic [SEG_W-1:0] s;
    case (d)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/occ_tick_gen.sv
module occ_tick_gen #(
  parameter int unsigned PERIOD = 100_000_000
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic clr_i,
  output logic tick_o
);

  localparam int unsigned W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || clr_i) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = !clr_i && (cnt_q == LAST);

  AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_o |=> !tick_o); // R3

endmodule

// File: rtl/occ_vacancy_timer.sv
module occ_vacancy_timer #(
  parameter int unsigned HOLD_SECS = 60
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       occupied_i,
  input  logic       tick_i,
  output logic [3:0] tens_o,
  output logic [3:0] ones_o,
  output logic       live_next_o
);

  localparam logic [3:0] HOLD_T = 4'(HOLD_SECS / 10);
  localparam logic [3:0] HOLD_O = 4'(HOLD_SECS % 10);

  logic [3:0] tens_q, ones_q, tens_d, ones_d;
  logic       at_zero;
  logic [7:0] secs_q;

  assign at_zero = (tens_q == 4'd0) && (ones_q == 4'd0);
  assign secs_q  = {4'd0, tens_q} * 8'd10 + {4'd0, ones_q};

  always_comb begin
    tens_d = tens_q;
    ones_d = ones_q;
    if (occupied_i) begin
      tens_d = HOLD_T;
      ones_d = HOLD_O;
    end else if (tick_i && !at_zero) begin
      if (ones_q == 4'd0) begin
        ones_d = 4'd9;
        tens_d = tens_q - 1'b1;
      end else begin
        ones_d = ones_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      tens_q <= '0;
      ones_q <= '0;
    end else begin
      tens_q <= tens_d;
      ones_q <= ones_d;
    end
  end

  assign tens_o      = tens_q;
  assign ones_o      = ones_q;
  assign live_next_o = (tens_d != 4'd0) || (ones_d != 4'd0);

  AST_RELOAD: assert property (@(posedge clk_i) disable iff (rst_i)
    occupied_i |=> (tens_q == HOLD_T && ones_q == HOLD_O)); // R5
  AST_ONE_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
    (!occupied_i && tick_i && !at_zero) |=> (secs_q == $past(secs_q) - 8'd1)); // R3
  AST_HOLD_BETWEEN: assert property (@(posedge clk_i) disable iff (rst_i)
    (!occupied_i && !tick_i) |=> $stable(secs_q)); // R3
  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
    (!occupied_i && at_zero) |=> at_zero); // R4
  AST_BCD_DIGIT: assert property (@(posedge clk_i) disable iff (rst_i)
    ones_q <= 4'd9); // R3

endmodule

// File: rtl/occ_seg_scan.sv
module occ_seg_scan
  import occ_pkg::*;
#(
  parameter int unsigned DWELL = 100_000
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [3:0]        tens_i,
  input  logic [3:0]        ones_i,
  output logic [SEG_W-1:0]  seg_n_o,
  output logic [DIGITS-1:0] an_n_o
);

  localparam int unsigned W     = (DWELL > 1) ? $clog2(DWELL) : 1;
  localparam logic [W-1:0] LAST = W'(DWELL - 1);
  localparam int unsigned SEL_W = $clog2(DIGITS);

  logic [W-1:0]     cnt_q;
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
      sel_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      sel_q <= sel_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar g = 0; g < DIGITS; g++) begin : g_anode
    assign an_n_o[g] = (sel_q != SEL_W'(g));
  end

  always_comb begin
    case (sel_q)
      SEL_W'(0): seg_n_o = ~seg_of_bcd(ones_i);
      SEL_W'(1): seg_n_o = ~seg_of_bcd(tens_i);
      default:   seg_n_o = '1;
    endcase
  end

  AST_ONE_ANODE: assert property (@(posedge clk_i) disable iff (rst_i)
    $countones(~an_n_o) == 1); // R7
  AST_DWELL_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (cnt_q != LAST) |=> $stable(an_n_o)); // R7
  AST_SPARE_BLANK: assert property (@(posedge clk_i) disable iff (rst_i)
    (an_n_o[0] && an_n_o[1]) |-> (seg_n_o == '1)); // R7

endmodule

// File: rtl/occupancy_lamp_ctrl.sv
module occupancy_lamp_ctrl
  import occ_pkg::*;
#(
  parameter int unsigned LAMPS       = 7,
  parameter int unsigned COUNT_W     = 3,
  parameter int unsigned TICK_CYCLES = 100_000_000,
  parameter int unsigned HOLD_SECS   = 60,
  parameter int unsigned SCAN_DWELL  = 100_000
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [COUNT_W-1:0] count_i,
  output logic [LAMPS-1:0]   lamps_o,
  output logic [SEG_W-1:0]   seg_n_o,
  output logic [DIGITS-1:0]  an_n_o
);

  logic             occupied;
  logic             tick;
  logic             live_next;
  logic [3:0]       tens, ones;
  logic [LAMPS-1:0] therm;
  logic [LAMPS-1:0] lamps_q;

  assign occupied = |count_i;

  for (genvar g = 0; g < LAMPS; g++) begin : g_therm
    assign therm[g] = int'(count_i) > g;
  end

  occ_tick_gen #(.PERIOD(TICK_CYCLES)) u_tick (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .clr_i  (occupied),
    .tick_o (tick)
  );

  occ_vacancy_timer #(.HOLD_SECS(HOLD_SECS)) u_timer (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .occupied_i  (occupied),
    .tick_i      (tick),
    .tens_o      (tens),
    .ones_o      (ones),
    .live_next_o (live_next)
  );

  occ_seg_scan #(.DWELL(SCAN_DWELL)) u_scan (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .tens_i  (tens),
    .ones_i  (ones),
    .seg_n_o (seg_n_o),
    .an_n_o  (an_n_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      lamps_q <= '0;
    end else if (occupied) begin
      lamps_q <= therm;
    end else begin
      lamps_q <= {{(LAMPS-1){1'b0}}, live_next};
    end
  end

  assign lamps_o = lamps_q;

  AST_LAMP_COUNT: assert property (@(posedge clk_i) disable iff (rst_i)
    (count_i != '0) |=> ($countones(lamps_o) == int'($past(count_i)))); // R1
  AST_THERMO_SHAPE: assert property (@(posedge clk_i) disable iff (rst_i)
    ((lamps_o & (lamps_o + 1'b1)) == '0)); // R1
  AST_VACANT_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
    (count_i == '0) |=> (lamps_o[LAMPS-1:1] == '0)); // R2
  AST_DARK_AT_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    (count_i == '0 && tens == 4'd0 && ones == 4'd0) |=> (lamps_o == '0)); // R4
  AST_RESET_STATE: assert property (@(posedge clk_i)
    rst_i |=> (lamps_o == '0 && an_n_o == 4'b1110)); // R8

endmodule

// File: tb/test_occupancy_lamp_ctrl.sv
module test_occupancy_lamp_ctrl;

  localparam int T = 20;  // TICK_CYCLES for the bench

  typedef struct {
    int         at;
    logic [6:0] lamps;
    int         secs;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] count = 3'd5;
  logic [6:0] lamps;
  logic [6:0] seg_n;
  logic [3:0] an_n;

  int   cyc = 0;
  int   base = 0;
  int   checks = 0;
  int   errors = 0;
  exp_t q[$];

  occupancy_lamp_ctrl #(
    .LAMPS(7), .COUNT_W(3), .TICK_CYCLES(T), .HOLD_SECS(60), .SCAN_DWELL(2)
  ) i_occupancy_lamp_ctrl (
    .clk_i(clk), .rst_i(rst), .count_i(count),
    .lamps_o(lamps), .seg_n_o(seg_n), .an_n_o(an_n)
  );

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [6:0] pat(input int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction

  function automatic logic [6:0] therm(input int c);
    logic [6:0] v = '0;
    for (int i = 0; i < c; i++) v[i] = 1'b1;
    return v;
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  // Monitor: compare each queued expectation in its target cycle.
  task automatic compare_item(input exp_t e);
    logic [6:0] want;
    chk(lamps == e.lamps, {e.tag, " lamps"}, lamps, e.lamps);
    case (an_n)
      4'b1110: want = ~pat(e.secs % 10);
      4'b1101: want = ~pat(e.secs / 10);
      4'b1011, 4'b0111: want = 7'h7F;
      default: want = 7'hxx;
    endcase
    chk(seg_n === want, {e.tag, " R6 display"}, seg_n, want);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].at <= cyc) begin
        exp_t e;
        e = q.pop_front();
        if (e.at < cyc) chk(1'b0, {e.tag, " missed slot"}, cyc, e.at);
        else compare_item(e);
      end
    end
  end

  // Driver
  task automatic apply(input int c);
    @(posedge clk);
    #2;
    count = 3'(c);
    base = cyc;
  endtask

  task automatic expect_at(input int m, input logic [6:0] l, input int s, input string tag);
    exp_t e;
    e.at = base + m; e.lamps = l; e.secs = s; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R8: reset state, even with a nonzero count applied
    repeat (3) @(negedge clk);
    chk(lamps == 7'h00, "R8 lamps in reset", lamps, 0);
    chk(an_n == 4'b1110, "R8 anodes in reset", an_n, 4'b1110);
    chk(seg_n == ~pat(0), "R8 shows 00", seg_n, ~pat(0));
    @(posedge clk); #2;
    rst = 1'b0; count = 3'd0; base = cyc;
    expect_at(1, 7'h00, 0, "R8");
    expect_at(7, 7'h00, 0, "R8");
    drain();

    // R7: scan visits all four digits in order
    begin
      logic [3:0] seen = '0;
      int         bad = 0;
      logic [3:0] prev;
      @(negedge clk);
      prev = an_n;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        seen = seen | ~an_n;
        if ($countones(~an_n) != 1) bad++;
        if (an_n != prev && an_n != {prev[2:0], prev[3]}) bad++;
        prev = an_n;
      end
      chk(seen == 4'hF, "R7 all digits scanned", seen, 4'hF);
      chk(bad == 0, "R7 one anode, ascending order", bad, 0);
    end

    // R1: thermometer for every count
    for (int c = 1; c <= 7; c++) begin
      apply(c);
      expect_at(1, therm(c), 60, "R1");
      expect_at(4, therm(c), 60, "R1");
      drain();
    end

    // R2/R3/R4: full countdown
    apply(3);
    expect_at(1, 7'h07, 60, "R1");
    drain();
    apply(0);
    expect_at(1, 7'h01, 60, "R2");
    expect_at(T - 1, 7'h01, 60, "R3");
    expect_at(T, 7'h01, 59, "R3");
    expect_at(10 * T + 3, 7'h01, 50, "R3");
    expect_at(11 * T, 7'h01, 49, "R3");
    expect_at(59 * T + 5, 7'h01, 1, "R4");
    expect_at(60 * T - 1, 7'h01, 1, "R4");
    expect_at(60 * T, 7'h00, 0, "R4");
    expect_at(60 * T + 50, 7'h00, 0, "R4");
    drain();

    // R5: arrival while stopped at 00
    apply(7);
    expect_at(1, 7'h7F, 60, "R5");
    drain();

    // R5: arrival mid-countdown, then restart of timebase
    apply(0);
    expect_at(30 * T + 4, 7'h01, 30, "R3");
    drain();
    apply(2);
    expect_at(1, 7'h03, 60, "R5");
    expect_at(T + 3, 7'h03, 60, "R5");
    drain();
    apply(0);
    expect_at(1, 7'h01, 60, "R2");
    expect_at(T - 1, 7'h01, 60, "R5");
    expect_at(T, 7'h01, 59, "R5");
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule